// File: doc/BRIEF.md
# Glitch-Robust Masked AND Gadget

This block computes the AND of two secret bits while neither bit ever appears in the clear. Each bit is carried as a sharing: a vector of `NSH` one-bit shares whose XOR is the bit's value. The result is a sharing of the same kind. The share count `NSH` is a parameter from 2 to 4. Each operation also takes `NSH*(NSH-1)/2` fresh random bits. These bits blind the cross-share products, so no output share depends on an unblinded combination of shares from different indices.

The two operands are timed differently. The lead operand and the random bits are applied in cycle t. The trail operand is applied in cycle t+1. The output sharing is valid from cycle t+2. Between the lead operand and the point where the trail operand is mixed in, every cross term passes through a register that holds it already XORed with its random bit. This keeps glitches from combining unmasked shares. The gadget is fully pipelined and accepts a new operation in every cycle. No separate refresh stage is needed around it, so a larger circuit can chain these gadgets with plain XOR and NOT logic between them.

Top module: `masked_and_gadget`

## Requirements
- R1: The XOR of all `prod_sh` shares sampled after edge t+2 equals (XOR of `lead_sh` captured at edge t+1) AND (XOR of `trail_sh` captured at edge t+2). This holds for all four combinations of the unshared values.
- R2: `lead_sh` is used only at the edge where it is captured, and `trail_sh` only one edge later. Values the operands carry in other cycles do not affect the result of that operation.
- R3: A new operation may start at every clock edge. Back-to-back operations that use independent operands and independent random bits each produce their own correct result, with no interference between them.
- R4: The recombined result does not depend on `rand_in`. The all-zero pattern, the all-ones pattern and arbitrary patterns all give the same unshared output. Random bit k blinds the share pair (i, j) with i < j, where k = i*NSH - i*(i+1)/2 + (j-i-1), and the bit is used for both (i, j) and (j, i).
- R5: The result does not depend on how an operand is split into shares. A trivial sharing (the value in share 0, all other shares zero) and uniformly random sharings give the same result.
- R6: Synchronous active-high `rst` clears every pipeline register. `prod_sh` is all zero in the cycle after a reset edge, and also in the following cycle, because the lead stage holds zeros.
- R7: The gadget works for `NSH` = 2, 3 and 4, with `rand_in` exactly `NSH*(NSH-1)/2` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lead_sh | input | NSH | Shares of the lead operand, cycle t |
| trail_sh | input | NSH | Shares of the trail operand, cycle t+1 |
| rand_in | input | NSH*(NSH-1)/2 | Fresh random bits for the operation started in cycle t |
| prod_sh | output | NSH | Shares of the product, valid from cycle t+2 |

## Verification
The difficult case is the operand skew under full throughput. Operations overlap, so a gadget that pairs the wrong cycle's trail operand with a lead operand still gives correct answers whenever the operands happen to repeat. The stimulus therefore draws fresh, independent unshared values, share splits and random bits in every cycle, and the bench predicts each result from the lead value of the cycle before and the trail value of the current cycle. Directed stretches pin the random bus to all-zero and all-ones and use trivial sharings, so that a misplaced random bit shows up in the recombined result. The same checks run on gadgets with two, three and four shares.

// File: rtl/mand_pkg.sv
package mand_pkg;

    // Number of fresh random bits per operation for d shares.
    function automatic int rand_width(input int d);
        return (d * (d - 1)) / 2;
    endfunction

    // Number of ordered off-diagonal share pairs.
    function automatic int cross_width(input int d);
        return d * (d - 1);
    endfunction

    // Index of the random bit shared by unordered pair {i, j}, i != j.
    function automatic int pair_index(input int i, input int j, input int d);
        int lo;
        int hi;
        lo = (i < j) ? i : j;
        hi = (i < j) ? j : i;
        return lo * d - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

    // Index of ordered cross term (i, j), i != j; row i occupies a
    // contiguous slice of d-1 entries.
    function automatic int cross_index(input int i, input int j, input int d);
        return i * (d - 1) + ((j < i) ? j : j - 1);
    endfunction

endpackage

// File: rtl/mand_lead_stage.sv
module mand_lead_stage #(
    parameter int NSH = 3,
    parameter int NR  = mand_pkg::rand_width(NSH),
    parameter int NX  = mand_pkg::cross_width(NSH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSH-1:0] lead_sh,
    input  logic [NR-1:0]  rand_in,
    output logic [NSH-1:0] lead_q,
    output logic [NR-1:0]  rand_q,
    output logic [NX-1:0]  blind_q
);
    logic [NX-1:0] blind_d;

    // Cross term (i, j) carries lead share j blinded by the pair's random bit.
    for (genvar i = 0; i < NSH; i++) begin : g_row
        for (genvar j = 0; j < NSH; j++) begin : g_col
            if (i != j) begin : g_cross
                localparam int CI = mand_pkg::cross_index(i, j, NSH);
                localparam int PI = mand_pkg::pair_index(i, j, NSH);
                assign blind_d[CI] = lead_sh[j] ^ rand_in[PI];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q  <= '0;
            rand_q  <= '0;
            blind_q <= '0;
        end else begin
            lead_q  <= lead_sh;
            rand_q  <= rand_in;
            blind_q <= blind_d;
        end
    end

    // R2: the lead stage holds exactly what was presented one edge earlier.
    assert_lead_capture_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lead_q == $past(lead_sh) && rand_q == $past(rand_in)));

endmodule

// File: rtl/mand_trail_stage.sv
module mand_trail_stage #(
    parameter int NSH = 3,
    parameter int NR  = mand_pkg::rand_width(NSH),
    parameter int NX  = mand_pkg::cross_width(NSH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSH-1:0] trail_sh,
    input  logic [NSH-1:0] lead_q,
    input  logic [NR-1:0]  rand_q,
    input  logic [NX-1:0]  blind_q,
    output logic [NSH-1:0] diag_q,
    output logic [NX-1:0]  rterm_q,
    output logic [NX-1:0]  xterm_q
);
    logic [NSH-1:0] diag_d;
    logic [NX-1:0]  rterm_d;
    logic [NX-1:0]  xterm_d;
    logic [NX-1:0]  unblind_chk;

    for (genvar i = 0; i < NSH; i++) begin : g_row
        assign diag_d[i] = trail_sh[i] & lead_q[i];
        for (genvar j = 0; j < NSH; j++) begin : g_col
            if (i != j) begin : g_cross
                localparam int CI = mand_pkg::cross_index(i, j, NSH);
                localparam int PI = mand_pkg::pair_index(i, j, NSH);
                // Selects either the bare random bit or the blinded lead share.
                assign rterm_d[CI]     = ~trail_sh[i] & rand_q[PI];
                assign xterm_d[CI]     =  trail_sh[i] & blind_q[CI];
                assign unblind_chk[CI] = blind_q[CI] ^ rand_q[PI] ^ lead_q[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            diag_q  <= '0;
            rterm_q <= '0;
            xterm_q <= '0;
        end else begin
            diag_q  <= diag_d;
            rterm_q <= rterm_d;
            xterm_q <= xterm_d;
        end
    end

    // R4: each blinded term and its random bit recover the lead share,
    // i.e. the same random bit is applied to both orderings of a pair.
    assert_blind_pairing_R4: assert property (@(posedge clk) disable iff (rst)
        unblind_chk == '0);

endmodule

// File: rtl/mand_fold.sv
module mand_fold #(
    parameter int NSH = 3,
    parameter int NX  = mand_pkg::cross_width(NSH)
) (
    input  logic [NSH-1:0] diag_q,
    input  logic [NX-1:0]  rterm_q,
    input  logic [NX-1:0]  xterm_q,
    output logic [NSH-1:0] prod_sh
);
    localparam int ROW = NSH - 1;

    // Only registered terms are combined here.
    for (genvar i = 0; i < NSH; i++) begin : g_out
        logic [ROW-1:0] row_terms;
        assign row_terms  = rterm_q[i*ROW +: ROW] ^ xterm_q[i*ROW +: ROW];
        assign prod_sh[i] = diag_q[i] ^ (^row_terms);
    end

endmodule

// File: rtl/masked_and_gadget.sv
module masked_and_gadget #(
    parameter int NSH = 3,
    localparam int NR = mand_pkg::rand_width(NSH),
    localparam int NX = mand_pkg::cross_width(NSH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NSH-1:0] lead_sh,
    input  logic [NSH-1:0] trail_sh,
    input  logic [NR-1:0]  rand_in,
    output logic [NSH-1:0] prod_sh
);
    if (NSH < 2 || NSH > 4) begin : g_bad_nsh
        $error("masked_and_gadget: NSH must be 2, 3 or 4");
    end

    logic [NSH-1:0] lead_q;
    logic [NR-1:0]  rand_q;
    logic [NX-1:0]  blind_q;
    logic [NSH-1:0] diag_q;
    logic [NX-1:0]  rterm_q;
    logic [NX-1:0]  xterm_q;

    mand_lead_stage #(.NSH(NSH), .NR(NR), .NX(NX)) u_lead (
        .clk     (clk),
        .rst     (rst),
        .lead_sh (lead_sh),
        .rand_in (rand_in),
        .lead_q  (lead_q),
        .rand_q  (rand_q),
        .blind_q (blind_q)
    );

    mand_trail_stage #(.NSH(NSH), .NR(NR), .NX(NX)) u_trail (
        .clk      (clk),
        .rst      (rst),
        .trail_sh (trail_sh),
        .lead_q   (lead_q),
        .rand_q   (rand_q),
        .blind_q  (blind_q),
        .diag_q   (diag_q),
        .rterm_q  (rterm_q),
        .xterm_q  (xterm_q)
    );

    mand_fold #(.NSH(NSH), .NX(NX)) u_fold (
        .diag_q  (diag_q),
        .rterm_q (rterm_q),
        .xterm_q (xterm_q),
        .prod_sh (prod_sh)
    );

    // Edges since reset, saturating at 2; used only by the checks below.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R1, R3: the recombined output is the AND of lead two edges back and trail one edge back.
    assert_product_R1: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> ((^prod_sh) == ((^$past(lead_sh, 2)) & (^$past(trail_sh, 1)))));

    // R6: the pipeline drains to zero shares during the first two cycles after reset.
    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (warm_q != 2'd2) |-> (prod_sh == '0));

endmodule

// File: tb/tb_masked_and_gadget.sv
module tb_masked_and_gadget;
    localparam int NCYC = 520;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [2:0] lead3, trail3, rnd3, prod3;
    logic [1:0] lead2, trail2, prod2;
    logic [0:0] rnd2;
    logic [3:0] lead4, trail4, prod4;
    logic [5:0] rnd4;

    masked_and_gadget #(.NSH(3)) dut (
        .clk(clk), .rst(rst), .lead_sh(lead3), .trail_sh(trail3),
        .rand_in(rnd3), .prod_sh(prod3));
    masked_and_gadget #(.NSH(2)) dut2 (
        .clk(clk), .rst(rst), .lead_sh(lead2), .trail_sh(trail2),
        .rand_in(rnd2), .prod_sh(prod2));
    masked_and_gadget #(.NSH(4)) dut4 (
        .clk(clk), .rst(rst), .lead_sh(lead4), .trail_sh(trail4),
        .rand_in(rnd4), .prod_sh(prod4));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit xh [0:NCYC-1];
    bit yh [0:NCYC-1];

    function automatic logic [3:0] split(input bit v, input logic [3:0] m,
                                         input int d, input bit trivial);
        logic [3:0] s;
        bit acc;
        s = '0;
        if (trivial) begin
            s[0] = v;
            return s;
        end
        acc = v;
        for (int k = 0; k < d - 1; k++) begin
            s[k] = m[k];
            acc  = acc ^ m[k];
        end
        s[d-1] = acc;
        return s;
    endfunction

    function automatic string tag_of(input int c);
        if (c == 0)  return "R6";
        if (c < 18)  return "R1";
        if (c < 100) return "R2";
        if (c < 200) return "R3";
        if (c < 400) return "R4";
        return "R5";
    endfunction

    function automatic bit expect_at(input int c);
        if (c == 0) return 1'b0;
        return xh[c-1] & yh[c];
    endfunction

    task automatic check(input string tag, input int d, input bit got, input bit exp, input int c);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s d=%0d cycle %0d: recombined %b expected %b", tag, d, c, got, exp);
        end
    endtask

    task automatic check_zero(input string tag);
        checks++;
        if (prod2 !== '0 || prod3 !== '0 || prod4 !== '0) begin
            fails++;
            $display("FAIL %s reset: shares %b/%b/%b expected all zero", tag, prod2, prod3, prod4);
        end
    endtask

    task automatic drive(input int c);
        bit xv, yv, triv;
        logic [5:0] r;
        logic [3:0] mx, my;
        r    = 6'($urandom);
        mx   = 4'($urandom);
        my   = 4'($urandom);
        xv   = 1'($urandom);
        yv   = 1'($urandom);
        triv = 1'b0;
        if (c < 18) begin
            // R1: truth table, both random extremes and both share splits
            xv = c[0];
            yv = c[1];
            r  = c[2] ? 6'h3f : 6'h00;
            if (c[3]) begin mx = '0; my = '0; end
        end else if (c >= 200 && c < 300) begin
            r = '0;          // R4: no randomness
        end else if (c >= 300 && c < 400) begin
            r = 6'h3f;       // R4: all random bits set
        end else if (c >= 400) begin
            triv = 1'b1;     // R5: value held in share 0 only
        end
        xh[c] = xv;
        yh[c] = yv;
        lead2  = 2'(split(xv, mx, 2, triv));
        trail2 = 2'(split(yv, my, 2, triv));
        lead3  = 3'(split(xv, mx, 3, triv));
        trail3 = 3'(split(yv, my, 3, triv));
        lead4  = split(xv, mx, 4, triv);
        trail4 = split(yv, my, 4, triv);
        rnd2   = r[0:0];
        rnd3   = r[2:0];
        rnd4   = r;
    endtask

    initial begin
        void'($urandom(32'h0000_5eed));
        lead2 = '1; trail2 = '1; rnd2 = '1;
        lead3 = '1; trail3 = '1; rnd3 = '1;
        lead4 = '1; trail4 = '1; rnd4 = '1;
        repeat (3) @(negedge clk);
        check_zero("R6");
        rst = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            drive(c);
            @(negedge clk);
            check(tag_of(c), 3, ^prod3, expect_at(c), c);
            check("R7", 2, ^prod2, expect_at(c), c);
            check("R7", 4, ^prod4, expect_at(c), c);
        end
        // R6: reset in mid-stream clears the pipeline
        rst = 1'b1;
        @(negedge clk);
        check_zero("R6");
        rst = 1'b0;
        @(negedge clk);
        check_zero("R6");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #((NCYC + 50) * 10 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule